// File: doc/BRIEF.md
# I2C Master Byte-Command Controller

This block is a single-master I2C engine that a host steers through five byte-wide register slots. The host sets the bit rate with a 16-bit divider, turns the engine on, puts a byte in the data slot, and then writes one command byte. That command can ask for a start condition, a byte sent, a byte received, a chosen acknowledge level and a closing stop, all in a single write. The engine then runs the whole sequence on its own. It drives SCL and SDA only through pull-low enables, reads both lines back, and reports its progress in a status byte that shares the command slot.

Every bus bit lasts five prescaled ticks. The divider reload value is `prescale + 1` core clocks, so one SCL period is `5 × (prescale + 1)` clocks. When a command finishes, or when the engine loses the bus to another master, a sticky flag is set. That flag stays up until a later command byte clears it, and the interrupt output follows it whenever interrupts are enabled.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the divider reads back 0xFFFF (slot 0 low byte, slot 1 high byte), the control slot (2) reads 0x00, the status slot (4) reads 0x00 and `irq` is low.
- R2: A write to slot 0 or 1 changes the divider only while control bit 7 (enable) is clear. While enable is set, such writes leave the readback unchanged.
- R3: During a byte, consecutive rising edges of SCL are exactly `5 × (divider + 1)` clock cycles apart. The engine never drives either line high; it only pulls low or releases.
- R4: Command bit 7 (start) together with bit 4 (write) produces a start condition, then the eight data-slot bits MSB first, then a released ACK bit whose sampled level lands in status bit 7 (1 = not acknowledged). SDA driven by the engine changes only while SCL is low.
- R5: Command bit 5 (read) shifts in eight bits MSB first, and slot 3 then reads the received byte. In the ACK bit the engine pulls SDA low, or releases it when command bit 3 is set.
- R6: Command bit 6 appends a stop condition after the byte. Status bit 6 (bus busy) sets when a start condition is seen on the lines and clears when a stop condition is seen.
- R7: Status bit 1 (in progress) is high from the cycle after a command is accepted until the command completes.
- R8: Status bit 0 sets when a command completes or arbitration is lost. It holds until a command byte with bit 0 set is written, and `irq` equals that bit ANDed with control bit 6.
- R9: If SDA reads low while the engine releases it during a written data bit, status bit 5 sets, the command ends, status bit 0 sets and both lines are released. The next accepted command clears bit 5.
- R10: While control bit 7 is clear, command writes start nothing: both line enables stay released and status bits 1 and 0 stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register slot select (0..4) |
| reg_we | input | 1 | Write strobe for the selected slot |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected slot |
| irq | output | 1 | Level interrupt |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
Suppose the phase counter or the divider reload is off by one. The spacing of SCL rising edges would then differ from `5 × (divider + 1)` on the second bit of the very first byte, well before the byte ends. A bit-counter or shift-order fault shows up when the transfer completes, as a wrong byte at the bench's slave model or in slot 3. A broken sticky flag or acknowledge capture shows in the status byte read right after completion. An arbitration fault leaves the engine clocking SCL on a bus it should have let go, which is visible on the next status read.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter logic [15:0] PRE_RST = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_STOP} st_t;

  st_t         st;
  logic [15:0] pre, cnt;
  logic [7:0]  ctrl, sr;
  logic [2:0]  ph, nbit;
  logic        c_sto, c_rd, c_wr, c_nack;
  logic        hold, smp, rxack, busy, al, iflag, scl_q, sda_q;
  logic        scl_lo, sda_lo;

  wire en     = ctrl[7];
  wire tip    = (st != S_IDLE);
  wire tick   = tip && (cnt == 16'd0);
  wire last   = tick && (ph == 3'd4);
  wire cmd_wr = reg_we && (reg_addr == 3'd4);
  wire go     = cmd_wr && en && !tip && (|reg_wdata[7:4]);
  wire lose   = tick && (ph == 3'd3) && (st == S_BIT) && c_wr && sr[7] && !sda_i;
  wire done   = last && ((st == S_STOP) || (st == S_ACK && !c_sto) ||
                         (st == S_START && !c_wr && !c_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pre <= PRE_RST; cnt <= 16'd0; ctrl <= 8'h00; sr <= 8'h00;
      ph <= 3'd0; nbit <= 3'd0; c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0;
      c_nack <= 1'b0; hold <= 1'b0; smp <= 1'b0; rxack <= 1'b0; al <= 1'b0;
      iflag <= 1'b0;
    end else begin
      if (reg_we && reg_addr == 3'd2) ctrl <= {reg_wdata[7:6], 6'b0};
      if (reg_we && !en && reg_addr == 3'd0) pre[7:0]  <= reg_wdata;
      if (reg_we && !en && reg_addr == 3'd1) pre[15:8] <= reg_wdata;
      if (reg_we && !tip && reg_addr == 3'd3) sr <= reg_wdata;
      cnt <= (!tip || cnt == 16'd0) ? pre : cnt - 16'd1;

      if (done || lose) iflag <= 1'b1;
      else if (cmd_wr && reg_wdata[0]) iflag <= 1'b0;

      if (!en) begin
        st <= S_IDLE; hold <= 1'b0; ph <= 3'd0;
      end else if (go) begin
        st <= reg_wdata[7] ? S_START : (|reg_wdata[5:4]) ? S_BIT : S_STOP;
        c_sto <= reg_wdata[6]; c_wr <= reg_wdata[4];
        c_rd <= reg_wdata[5] & ~reg_wdata[4]; c_nack <= reg_wdata[3];
        ph <= 3'd0; nbit <= 3'd0; al <= 1'b0;
      end else if (lose) begin
        st <= S_IDLE; hold <= 1'b0; al <= 1'b1; ph <= 3'd0;
      end else if (tick) begin
        ph <= last ? 3'd0 : ph + 3'd1;
        if (ph == 3'd3) smp <= sda_i;
        if (ph == 3'd3 && st == S_ACK) rxack <= sda_i;
        if (last) begin
          case (st)
            S_START: begin
              st <= (c_wr || c_rd) ? S_BIT : c_sto ? S_STOP : S_IDLE;
              hold <= 1'b1; nbit <= 3'd0;
            end
            S_BIT: begin
              sr <= {sr[6:0], smp};
              if (nbit == 3'd7) st <= S_ACK;
              nbit <= nbit + 3'd1;
            end
            S_ACK:   st <= c_sto ? S_STOP : S_IDLE;
            default: begin st <= S_IDLE; hold <= 1'b0; end
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_START: begin scl_lo = (ph == 3'd0 && hold) || ph == 3'd4; sda_lo = (ph >= 3'd3); end
      S_BIT:   begin scl_lo = (ph < 3'd2) || ph == 3'd4;           sda_lo = c_wr && !sr[7]; end
      S_ACK:   begin scl_lo = (ph < 3'd2) || ph == 3'd4;           sda_lo = c_rd && !c_nack; end
      S_STOP:  begin scl_lo = (ph == 3'd0);                        sda_lo = (ph < 3'd3); end
      default: begin scl_lo = hold;                                sda_lo = 1'b0; end
    endcase
  end
  assign scl_oe = scl_lo;
  assign sda_oe = sda_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; busy <= 1'b0;
    end else begin
      scl_q <= scl_i; sda_q <= sda_i;
      if (scl_i && scl_q && sda_q && !sda_i) busy <= 1'b1;
      else if (scl_i && scl_q && !sda_q && sda_i) busy <= 1'b0;
    end
  end

  assign irq = iflag & ctrl[6];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = pre[7:0];
      3'd1:    reg_rdata = pre[15:8];
      3'd2:    reg_rdata = ctrl;
      3'd3:    reg_rdata = sr;
      3'd4:    reg_rdata = {rxack, busy, al, 3'b000, tip, iflag};
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_PRE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr < 3'd2 && en) |=> $stable(pre)); // R2
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && !$stable(sda_oe)) |-> scl_oe); // R4
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tip) && en) |-> iflag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (iflag && !(cmd_wr && reg_wdata[0])) |=> iflag); // R8
  AST_ARB_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al) |-> (!tip && !scl_oe && !sda_oe)); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tip && !scl_oe && !sda_oe)); // R10
endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq, scl_oe, sda_oe, scl_bus, sda_bus;
  logic sl_pull = 1'b0;
  logic [8:0] sl_bits = 9'h1FF;
  int sl_idx = 9, rise_n = 0, t2 = 0, t3 = 0, cyc = 0;
  logic ack_got = 1'b0, ack_seen = 1'b0, pscl = 1'b1, psda = 1'b1;
  logic [7:0] rx = 8'h00;
  int nchk = 0, nfail = 0;

  assign scl_bus = ~scl_oe;
  assign sda_bus = ~sda_oe & ~sl_pull;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_bus), .scl_oe(scl_oe), .sda_i(sda_bus), .sda_oe(sda_oe));

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (scl_bus && pscl && psda && !sda_bus) begin
      sl_idx = 0; ack_got = 1'b0; rise_n = 0;
    end
    pscl = scl_bus; psda = sda_bus;
  end
  always @(negedge scl_bus) begin
    if (sl_idx < 9) begin sl_pull = !sl_bits[8 - sl_idx]; sl_idx++; end
    else sl_pull = 1'b0;
  end
  always @(posedge scl_bus) begin
    rise_n++;
    if (rise_n == 2) t2 = cyc;
    if (rise_n == 3) t3 = cyc;
    if (sl_idx >= 1 && sl_idx <= 8) rx = {rx[6:0], sda_bus};
    if (sl_idx == 9 && !ack_got) begin ack_seen = sda_bus; ack_got = 1'b1; end
  end

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 60000; i++) begin
      rd(3'd4, s);
      if (!s[1]) break;
    end
  endtask

  task automatic xfer(input int pre, input logic [7:0] b, input bit is_rd, input bit flag);
    logic [7:0] s, d;
    wr(3'd2, 8'h00); wr(3'd0, pre[7:0]); wr(3'd1, pre[15:8]); wr(3'd2, 8'hC0);
    wr(3'd4, 8'h01);
    if (!is_rd) begin wr(3'd3, b); sl_bits = {8'hFF, flag}; end
    else sl_bits = {b, 1'b1};
    rise_n = 0;
    wr(3'd4, is_rd ? (flag ? 8'hE8 : 8'hE0) : 8'hD0);
    wait (rise_n >= 1);
    rd(3'd4, s);
    chk("R7 in-progress mid byte", s[1], 1);
    chk("R6 busy after start", s[6], 1);
    wait_idle();
    chk("R3 scl period", t3 - t2, 5 * (pre + 1));
    chk("R4/R5 byte on bus", rx, b);
    rd(3'd4, s);
    chk("R6 busy cleared by stop", s[6], 0);
    chk("R8 flag set on completion", s[0], 1);
    chk("R8 irq with enable", irq, 1);
    if (is_rd) begin
      rd(3'd3, d);
      chk("R5 received byte", d, b);
      chk("R5 ack level driven", ack_seen, flag);
    end else chk("R4 ack status", s[7], flag);
    wr(3'd4, 8'h01);
    rd(3'd4, s);
    chk("R8 flag cleared", s[0], 0);
    chk("R8 irq cleared", irq, 0);
    chk("R3 lines released", {scl_bus, sda_bus}, 3);
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, d); chk("R1 divider low", d, 8'hFF);
    rd(3'd1, d); chk("R1 divider high", d, 8'hFF);
    rd(3'd2, d); chk("R1 control", d, 8'h00);
    rd(3'd4, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 0);

    wr(3'd2, 8'h80); wr(3'd0, 8'h12);
    rd(3'd0, d); chk("R2 divider locked", d, 8'hFF);
    wr(3'd2, 8'h00); wr(3'd0, 8'h12);
    rd(3'd0, d); chk("R2 divider written", d, 8'h12);

    wr(3'd4, 8'hD0);
    repeat (100) @(negedge clk);
    chk("R10 scl released", scl_bus, 1);
    chk("R10 sda released", sda_bus, 1);
    rd(3'd4, s); chk("R10 no activity", s[1:0], 0);

    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int op = 0; op < 2; op++)
          xfer(p, 8'((p * 37 + k * 73 + 5) & 255), op[0], k[0]);
    xfer(300, 8'hA5, 1'b0, 1'b0);

    wr(3'd2, 8'h00); wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h80);
    wr(3'd3, 8'hFF); sl_bits = 9'b110111111;
    wr(3'd4, 8'h90);
    wait_idle();
    rd(3'd4, s);
    chk("R9 arbitration lost bit", s[5], 1);
    chk("R9 flag on loss", s[0], 1);
    chk("R8 irq masked", irq, 0);
    chk("R9 scl released", scl_bus, 1);
    chk("R9 sda not driven", sda_oe, 0);
    wr(3'd2, 8'hC0);
    chk("R8 irq unmasked", irq, 1);
    @(negedge clk); sl_pull = 1'b0; sl_idx = 9;
    wr(3'd4, 8'h41);
    wait_idle();
    rd(3'd4, s);
    chk("R9 loss cleared by next command", s[5], 0);
    chk("R6 idle after stop", s[6], 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule